// File: doc/BRIEF.md
# Multi-Bus I2C Byte Master

This engine performs the bit-level waveforms of an I2C controller on one of several buses that share packed pin vectors. A single command picks a bus and one of five operations: bus init with a stuck-data check, START, STOP, byte write with acknowledge sampling, and byte read with optional acknowledge generation. The engine holds `busy` while it works and pulses `done` for one cycle when it finishes. At that moment the received byte, the acknowledge flag and the stuck-line flag are valid. They stay unchanged until an operation of the kind that updates them runs again.

Each bus n uses two bits of the shared vectors. SCL is driven push-pull: its enable is set and its level is written directly. SDA is open-drain: its output value is always 0, so it is pulled low by enabling it and released by disabling it. Every pin change is followed by one half-period of `CLK_HZ/10000` system cycles. At system clock rates this gives an SCL of about 5 kHz. A bus index at or beyond `NBUS` touches no pin, and its SDA reads as 1.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `busy`, `done`, `rdata`, `ack_seen`, `err_stuck` and every bit of `pin_out` and `pin_oe` are 0.
- R2: A command is taken only when `cmd_valid` is high, `busy` is low and `cmd_op` is 0 (init), 1 (START), 2 (STOP), 3 (write) or 4 (read). Any other op code, and any command presented while busy, is ignored. `done` is high for exactly one cycle per accepted command, and a new command may be accepted in that same cycle.
- R3: Every step lasts H = CLK_HZ/10000 cycles. If a command is accepted at clock edge A, `done` is high in the cycle after edge A + S·H. S is 2 for init, 2 for START, 3 for STOP, 18 for write and 19 for read.
- R4: For bus n, SCL is bit 2n and SDA is bit 2n+1 of `pin_in`, `pin_out` and `pin_oe`. The SDA bit of `pin_out` is always 0. Bits of buses other than the selected one never change, and no pin changes while idle.
- R5: Init enables SCL and drives it high, releases SDA, waits two steps, then samples SDA. `err_stuck` is set to 1 if SDA is low and to 0 if it is high.
- R6: At the end of START, SCL is high and SDA is pulled low. At the end of STOP, SCL is high and SDA is released.
- R7: A write shifts `cmd_wdata` out MSB first. A 0 bit pulls SDA low and a 1 bit releases it, and each bit is set up while SCL is low. After the 8th bit, SDA is released for a ninth SCL pulse and `ack_seen` becomes 1 exactly when SDA is sampled low.
- R8: A read releases SDA only after SCL has been low for one step. It then samples 8 bits MSB first into `rdata`. On the ninth SCL pulse, SDA is pulled low if `cmd_ack` was 1 and released otherwise, and it is left that way at `done`.
- R9: For a bus index of NBUS or more, no pin changes and SDA reads as 1. A write then reports `ack_seen` = 0, a read reports `rdata` = 8'hFF, and init reports `err_stuck` = 0.
- R10: During a write or read, the SDA enable of the selected bus never changes while SCL stays high.
- R11: `ack_seen` is updated only by write, `rdata` only by read and `err_stuck` only by init. Other operations leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code (0 init, 1 START, 2 STOP, 3 write, 4 read) |
| cmd_bus | input | BUS_W | Bus index |
| cmd_wdata | input | 8 | Byte to send for write |
| cmd_ack | input | 1 | Read: acknowledge the byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte received by the last read |
| ack_seen | output | 1 | Acknowledge seen by the last write |
| err_stuck | output | 1 | Last init found SDA low |
| pin_in | input | 2*NBUS | Sensed SCL/SDA levels, packed per bus |
| pin_out | output | 2*NBUS | Output levels, packed per bus |
| pin_oe | output | 2*NBUS | Output enables, packed per bus |

## Verification
The end of one operation and the start of the next share a cycle. `busy` falls in the cycle where `done` is high, so a command already waiting is accepted in that same cycle. The bench issues the next command as soon as the previous one's target activity is over, so START, write, read and STOP run back to back on each bus. The scoreboard then judges the two functions together. For each operation it checks that the `done` pulse comes exactly S·H cycles after its own acceptance edge, and that the results and pin states still belong to that operation, not to the one accepted beside it.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int CLK_HZ = 100_000_000,
  parameter int NBUS   = 2,
  parameter int BUS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BUS_W-1:0]  cmd_bus,
  input  logic [7:0]        cmd_wdata,
  input  logic              cmd_ack,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata,
  output logic              ack_seen,
  output logic              err_stuck,
  input  logic [2*NBUS-1:0] pin_in,
  output logic [2*NBUS-1:0] pin_out,
  output logic [2*NBUS-1:0] pin_oe
);
  localparam int HALF = (CLK_HZ / 10000 < 1) ? 1 : CLK_HZ / 10000;
  localparam int CW   = $clog2(HALF + 1);
  localparam int PW   = 2 * NBUS;
  localparam logic [2:0] OP_INIT = 3'd0, OP_START = 3'd1, OP_STOP = 3'd2,
                         OP_WR = 3'd3, OP_RD = 3'd4;

  logic [2:0]       op_r;
  logic [BUS_W-1:0] bus_r;
  logic [7:0]       sh_r;
  logic             ack_r;
  logic [4:0]       step;
  logic [CW-1:0]    cnt;

  logic          bus_ok, sda_in, step_end;
  logic [PW-1:0] scl_m, sda_m, out_nx, oe_nx;
  logic          scl_set, scl_v, scl_en, sda_set, sda_pull, smp, last;

  assign bus_ok   = 32'(bus_r) < NBUS;
  assign scl_m    = bus_ok ? (PW'(1) << {bus_r, 1'b0}) : '0;
  assign sda_m    = bus_ok ? (PW'(2) << {bus_r, 1'b0}) : '0;
  assign sda_in   = bus_ok ? |(pin_in & sda_m) : 1'b1;
  assign step_end = cnt == CW'(HALF - 1);

  always_comb begin
    scl_set = 1'b0; scl_v = 1'b0; scl_en = 1'b0;
    sda_set = 1'b0; sda_pull = 1'b0; smp = 1'b0; last = 1'b0;
    case (op_r)
      OP_INIT: begin
        if (step == 5'd0) begin
          scl_set = 1'b1; scl_v = 1'b1; scl_en = 1'b1; sda_set = 1'b1;
        end
        last = step == 5'd1;
        smp  = last;
      end
      OP_START: begin
        if (step == 5'd0) begin
          scl_set = 1'b1; scl_v = 1'b1;
        end else begin
          sda_set = 1'b1; sda_pull = 1'b1;
        end
        last = step == 5'd1;
      end
      OP_STOP: begin
        case (step)
          5'd0: scl_set = 1'b1;
          5'd1: begin
            scl_set = 1'b1; scl_v = 1'b1; sda_set = 1'b1; sda_pull = 1'b1;
          end
          default: sda_set = 1'b1;
        endcase
        last = step == 5'd2;
      end
      OP_WR: begin
        if (step < 5'd16) begin
          scl_set = 1'b1;
          scl_v   = step[0];
          if (!step[0]) begin
            sda_set = 1'b1; sda_pull = !sh_r[7];
          end
        end else if (step == 5'd16) begin
          scl_set = 1'b1;
        end else begin
          scl_set = 1'b1; scl_v = 1'b1; sda_set = 1'b1; smp = 1'b1; last = 1'b1;
        end
      end
      OP_RD: begin
        if (step <= 5'd16) begin
          scl_set = 1'b1;
          scl_v   = step != 5'd0 && !step[0];
          smp     = scl_v;
          sda_set = step == 5'd1;
        end else if (step == 5'd17) begin
          scl_set = 1'b1; sda_set = ack_r; sda_pull = 1'b1;
        end else begin
          scl_set = 1'b1; scl_v = 1'b1; last = 1'b1;
        end
      end
      default: last = 1'b1;
    endcase
  end

  always_comb begin
    out_nx = pin_out & ~sda_m;
    oe_nx  = pin_oe;
    if (scl_set) out_nx = scl_v ? (out_nx | scl_m) : (out_nx & ~scl_m);
    if (scl_en)  oe_nx  = oe_nx | scl_m;
    if (sda_set) oe_nx  = sda_pull ? (oe_nx | sda_m) : (oe_nx & ~sda_m);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rdata <= '0; ack_seen <= 1'b0; err_stuck <= 1'b0;
      pin_out <= '0; pin_oe <= '0;
      op_r <= '0; bus_r <= '0; sh_r <= '0; ack_r <= 1'b0; step <= '0; cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid && cmd_op <= OP_RD) begin
          busy  <= 1'b1;
          op_r  <= cmd_op;
          bus_r <= cmd_bus;
          sh_r  <= cmd_wdata;
          ack_r <= cmd_ack;
          step  <= '0;
          cnt   <= '0;
        end
      end else begin
        if (cnt == '0) begin
          pin_out <= out_nx;
          pin_oe  <= oe_nx;
        end
        if (step_end) begin
          cnt  <= '0;
          step <= step + 5'd1;
          if (op_r == OP_WR && step < 5'd16 && step[0]) sh_r <= {sh_r[6:0], 1'b0};
          if (op_r == OP_RD && smp) sh_r <= {sh_r[6:0], sda_in};
          if (op_r == OP_WR && smp) ack_seen <= !sda_in;
          if (op_r == OP_INIT && smp) err_stuck <= !sda_in;
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
            step <= '0;
            if (op_r == OP_RD) rdata <= sh_r;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  // R4
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(pin_out) && $stable(pin_oe)));
  // R9
  bad_bus_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ok) |=> ($stable(pin_out) && $stable(pin_oe)));

  for (genvar b = 0; b < NBUS; b++) begin : g_bus_chk
    // R4
    sda_level_chk: assert property (@(posedge clk) disable iff (!rst_n) !pin_out[2*b+1]);
    // R10
    data_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (op_r == OP_WR || op_r == OP_RD) && 32'(bus_r) == b &&
       pin_out[2*b] && $past(pin_out[2*b])) |-> $stable(pin_oe[2*b+1]));
  end
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam int CLK_HZ = 40000;
  localparam int H      = CLK_HZ / 10000;
  localparam int NBUS   = 2;
  localparam int BUS_W  = 2;
  localparam int PW     = 2 * NBUS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ack = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [BUS_W-1:0] cmd_bus = '0;
  logic [7:0] cmd_wdata = '0;
  logic busy, done, ack_seen, err_stuck;
  logic [7:0] rdata;
  logic [PW-1:0] pin_in, pin_out, pin_oe;
  logic [NBUS-1:0] tgt_low = '0, stuck = '0;

  always #2.5 clk = ~clk;

  i2c_byte_master #(.CLK_HZ(CLK_HZ), .NBUS(NBUS), .BUS_W(BUS_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bus(cmd_bus),
    .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .busy(busy), .done(done), .rdata(rdata),
    .ack_seen(ack_seen), .err_stuck(err_stuck), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe));

  always_comb begin
    for (int b = 0; b < NBUS; b++) begin
      pin_in[2*b]   = pin_oe[2*b] ? pin_out[2*b] : 1'b1;
      pin_in[2*b+1] = !(pin_oe[2*b+1] && !pin_out[2*b+1]) && !tgt_low[b] && !stuck[b];
    end
  end

  typedef struct {
    int op; int bus; int cyc; int wdata;
    logic [7:0] rd; logic ack; logic err;
    logic [PW-1:0] oe; logic [PW-1:0] out;
  } item_t;
  item_t q[$];

  int cyc = 0, checks = 0, errors = 0;
  bit reported = 0;
  logic [7:0] m_rd = '0;
  logic m_ack = 1'b0, m_err = 1'b0;
  logic [PW-1:0] m_oe = '0, m_out = '0;
  logic [8:0] cap = '0;
  logic [NBUS-1:0] prev_scl = '1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].bus < NBUS) begin
        if (pin_in[2*q[0].bus] && !prev_scl[q[0].bus])
          cap = {cap[7:0], pin_in[2*q[0].bus+1]};
      end
      for (int b = 0; b < NBUS; b++) prev_scl[b] = pin_in[2*b];
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R2", "done with nothing pending", 1, 0);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, "R3", "done cycle", cyc, e.cyc);
          chk(rdata == e.rd, "R8/R9/R11", "rdata", rdata, e.rd);
          chk(ack_seen == e.ack, "R7/R9/R11", "ack_seen", ack_seen, e.ack);
          chk(err_stuck == e.err, "R5/R9/R11", "err_stuck", err_stuck, e.err);
          chk(pin_oe == e.oe, "R4/R6/R8", "pin_oe", pin_oe, e.oe);
          chk(pin_out == e.out, "R4/R6", "pin_out", pin_out, e.out);
          if (e.op == 3 && e.bus < NBUS)
            chk(cap[8:1] == e.wdata[7:0], "R7", "bits on SDA at SCL rise", cap[8:1], e.wdata);
        end
        cap = '0;
      end
    end
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run(input int op, input int bus, input logic [7:0] wd, input logic ack,
                     input logic [7:0] tbyte, input logic tack);
    item_t e;
    int n, a, s, d;
    bit ok;
    ok = bus < NBUS;
    s = 2 * bus; d = 2 * bus + 1;
    case (op)
      0: begin
        n = 2; m_err = ok ? stuck[bus] : 1'b0;
        if (ok) begin m_oe[s] = 1; m_out[s] = 1; m_oe[d] = 0; end
      end
      1: begin n = 2; if (ok) begin m_out[s] = 1; m_oe[d] = 1; end end
      2: begin n = 3; if (ok) begin m_out[s] = 1; m_oe[d] = 0; end end
      3: begin n = 18; m_ack = ok ? tack : 1'b0; if (ok) begin m_out[s] = 1; m_oe[d] = 0; end end
      default: begin
        n = 19; m_rd = ok ? tbyte : 8'hFF;
        if (ok) begin m_out[s] = 1; m_oe[d] = ack; end
      end
    endcase
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_bus = BUS_W'(bus); cmd_wdata = wd; cmd_ack = ack;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    a = cyc;
    e.op = op; e.bus = bus; e.cyc = a + n * H; e.wdata = int'(wd);
    e.rd = m_rd; e.ack = m_ack; e.err = m_err; e.oe = m_oe; e.out = m_out;
    q.push_back(e);
    if (ok && op == 3) begin
      wait_cyc(a + 16 * H + 2); tgt_low[bus] = tack;
      wait_cyc(a + 18 * H); tgt_low[bus] = 0;
    end
    if (ok && op == 4) begin
      for (int i = 0; i < 8; i++) begin
        wait_cyc(a + (1 + 2 * i) * H + 2);
        tgt_low[bus] = !tbyte[7-i];
      end
      wait_cyc(a + 17 * H + 2); tgt_low[bus] = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(pin_oe == 0 && pin_out == 0, "R1", "pins after reset", {pin_oe, pin_out}, 0);
    chk(rdata == 0 && !ack_seen && !err_stuck, "R1", "results after reset",
        {rdata, ack_seen, err_stuck}, 0);

    // R5 init, clean and stuck
    run(0, 0, 0, 0, 0, 0);
    stuck[1] = 1;
    run(0, 1, 0, 0, 0, 0);
    @(negedge clk); while (busy) @(negedge clk);
    stuck[1] = 0;
    run(0, 1, 0, 0, 0, 0);

    // R6 R7 R8 R11 back-to-back traffic on bus 0
    run(1, 0, 0, 0, 0, 0);
    run(3, 0, 8'hA5, 0, 0, 1);
    run(3, 0, 8'h3C, 0, 0, 0);
    run(4, 0, 0, 1, 8'h96, 0);
    run(4, 0, 0, 0, 8'h5A, 0);
    run(2, 0, 0, 0, 0, 0);

    // R2 command while busy is ignored
    run(1, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(busy, "R2", "busy during START", busy, 1);
    cmd_valid = 1; cmd_op = 3'd2; cmd_bus = '0;
    @(negedge clk);
    cmd_valid = 0;
    run(2, 0, 0, 0, 0, 0);

    // R2 undefined op code is ignored
    @(negedge clk); while (busy) @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd7; cmd_bus = '0;
    @(negedge clk);
    cmd_valid = 0;
    repeat (3) @(negedge clk);
    chk(!busy, "R2", "undefined op not accepted", busy, 0);

    // R9 out-of-range buses
    run(3, 2, 8'h00, 0, 0, 1);
    run(4, 3, 0, 1, 8'h00, 0);
    stuck[0] = 1;
    run(0, 2, 0, 0, 0, 0);
    @(negedge clk); while (busy) @(negedge clk);
    stuck[0] = 0;

    // R4 R7 traffic on bus 1 leaves bus 0 bits alone
    run(1, 1, 0, 0, 0, 0);
    run(3, 1, 8'h81, 0, 0, 1);
    run(4, 1, 0, 0, 8'hFF, 0);
    run(2, 1, 0, 0, 0, 0);

    @(negedge clk); while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2", "pending completions", q.size(), 0);
    report();
  end
endmodule